// File: doc/BRIEF.md
# I2S Transmit Serializer with Clock Divider

This block is the transmit engine of an I2S master. It runs from a master clock and derives the bit clock from it through a programmable ratio. It drives the word-select line and shifts stereo samples out MSB first at a resolution chosen at run time. Each channel sample comes from one 32-bit word that an upstream queue offers on a valid/pop interface. For every data frame the block consumes exactly two words, left first and then right.

After transmit is enabled, the block sends one complete frame of silence before it sends any queued data. If the queue has no word when a channel slot needs one, the block sends zeros and raises an underrun flag. It never stalls the serial stream. When transmit is disabled, the block finishes the frame in progress and then holds the data line low. Register decoding, queue storage and interrupt generation belong to neighbouring blocks.

Top module: `i2s_tx_serializer`

## Requirements
- R1: `bclk` is low after reset and then toggles every `ratio`+2 master clocks, so one full bit-clock period is 2*(`ratio`+2) master clocks.
- R2: Each channel slot lasts `res` bit-clock periods and a frame lasts 2*`res`. A `res` of 0 acts as 1 and a value above 32 acts as 32.
- R3: The serialized sample is the low `res` bits of the 32-bit word, sent most significant bit first.
- R4: `ws` is 0 during the left slot and 1 during the right slot. It changes at the falling edge that presents the last bit of the previous slot, which is one bit clock before the next slot's first bit.
- R5: `sdata` and `ws` change only together with a falling edge of `bclk`.
- R6: A frame starts at the falling edge that begins a left slot. The first frame that starts with `tx_en` high after a disabled period carries all zeros and pops no word. Queued data begins with the next frame.
- R7: In a data frame, `word_pop` pulses for one master clock at the start of the left slot and again at the start of the right slot, and only while `word_valid` is high. Each pulse consumes the word on `word_data`.
- R8: If no word is offered at a slot start where one is needed, that slot is sent as zeros and `underrun` goes to 1. A missing left word makes the whole frame zero and suppresses the right pop. `underrun` returns to 0 at the next frame start that finds no shortage.
- R9: When `tx_en` is low at a frame start, that frame and all later frames carry zeros and pop nothing. Clearing `tx_en` during a data frame still completes that frame, including its right-channel pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable, sampled at frame starts |
| ratio | input | 8 | Bit-clock divider setting; half period is ratio+2 master clocks |
| res | input | 6 | Sample resolution in bits per channel |
| word_data | input | 32 | Sample word offered by the upstream queue |
| word_valid | input | 1 | Upstream queue holds a word |
| word_pop | output | 1 | One-cycle strobe consuming the offered word |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 = left, 1 = right |
| sdata | output | 1 | Serial data, changes on falling bclk |
| underrun | output | 1 | A needed word was missing in the current frame |

## Verification
A slip in the bit counter or the word-select toggle shows at the ports within one channel slot. The received word then has the wrong bit count, or its bits are shifted against the expected masked value. A wrong primed or frame-mode state shows within one or two frames: a data frame replaces the silent frame, or the pop count after a run differs from twice the number of data frames. A divider error changes the measured bit-clock period at the very next bit-clock cycle.

// File: rtl/i2s_tx_serializer.sv
`timescale 1ns/1ps
module i2s_tx_serializer #(
  parameter int WORD_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [RES_W-1:0]   res,
  input  logic [WORD_W-1:0]  word_data,
  input  logic               word_valid,
  output logic               word_pop,
  output logic               bclk,
  output logic               ws,
  output logic               sdata,
  output logic               underrun
);

  localparam int CNT_W = RATIO_W + 1;
  localparam logic [RES_W-1:0] RES_MAX = RES_W'(WORD_W);

  logic [CNT_W-1:0]  div_cnt, half_term;
  logic [RES_W-1:0]  res_eff, bit_cnt;
  logic [WORD_W-1:0] shreg, aligned;
  logic tick, fall, chan_start, last_bit, left_start, right_start;
  logic primed, data_frame, need;

  assign res_eff     = (res == '0) ? RES_W'(1) : ((res > RES_MAX) ? RES_MAX : res);
  assign half_term   = {1'b0, ratio} + CNT_W'(1);
  assign tick        = (div_cnt >= half_term);
  assign fall        = tick & bclk;
  assign chan_start  = (bit_cnt == '0);
  assign last_bit    = (bit_cnt >= res_eff - RES_W'(1));
  assign left_start  = fall & chan_start & ~ws;
  assign right_start = fall & chan_start & ws;
  assign need        = left_start ? (tx_en & primed) : (right_start & data_frame);
  assign word_pop    = need & word_valid;
  assign aligned     = (word_pop ? word_data : '0) << (RES_MAX - res_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      bclk    <= ~bclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      ws      <= 1'b0;
      sdata   <= 1'b0;
      shreg   <= '0;
    end else if (fall) begin
      bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      if (last_bit) ws <= ~ws;
      if (chan_start) begin
        sdata <= aligned[WORD_W-1];
        shreg <= aligned << 1;
      end else begin
        sdata <= shreg[WORD_W-1];
        shreg <= shreg << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed     <= 1'b0;
      data_frame <= 1'b0;
      underrun   <= 1'b0;
    end else if (left_start) begin
      primed     <= tx_en;
      data_frame <= tx_en & primed & word_valid;
      underrun   <= need & ~word_valid;
    end else if (right_start && need && !word_valid) begin
      underrun   <= 1'b1;
    end
  end

  assert_bclk_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bclk));
  assert_ws_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(bclk));
  assert_sdata_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk));
  assert_silent_prime_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !word_pop);
  assert_pop_at_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_pop |=> $fell(bclk));
  assert_underrun_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $fell(bclk));

endmodule

// File: tb/i2s_tx_serializer_bench.sv
`timescale 1ns/1ps
module i2s_tx_serializer_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tx_en, word_valid, word_pop, bclk, ws, sdata, underrun;
  logic [7:0]  ratio;
  logic [5:0]  res;
  logic [31:0] word_data;

  i2s_tx_serializer u_i2s_tx_serializer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ratio(ratio), .res(res),
    .word_data(word_data), .word_valid(word_valid), .word_pop(word_pop),
    .bclk(bclk), .ws(ws), .sdata(sdata), .underrun(underrun));

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [31:0] fifo_mem [0:255];
  int wr_cnt = 0, rd_ptr = 0;
  assign word_valid = (rd_ptr < wr_cnt);
  assign word_data  = fifo_mem[rd_ptr[7:0]];
  always @(posedge clk) if (word_pop) rd_ptr <= rd_ptr + 1;

  int mcyc = 0;
  always @(posedge clk) mcyc++;

  int fidx = 0, nb = 0;
  logic ws1 = 1'b0, ws2 = 1'b0;
  logic [63:0] acc = '0;
  logic [63:0] fr_l [0:1023];
  logic [63:0] fr_r [0:1023];
  int nb_l [0:1023];
  int nb_r [0:1023];
  bit ur_l [0:1023];
  bit ur_r [0:1023];

  always @(posedge bclk) begin
    logic [63:0] a;
    int n;
    if (ws1 != ws2) begin
      a = {63'b0, sdata};
      n = 1;
      if (!ws1) begin
        fidx = fidx + 1;
        ur_l[fidx & 1023] = underrun;
      end else begin
        ur_r[fidx & 1023] = underrun;
      end
    end else begin
      a = {acc[62:0], sdata};
      n = nb + 1;
    end
    if (ws != ws1) begin
      if (!ws1) begin fr_l[fidx & 1023] = a; nb_l[fidx & 1023] = n; end
      else      begin fr_r[fidx & 1023] = a; nb_r[fidx & 1023] = n; end
    end
    acc = a; nb = n; ws2 = ws1; ws1 = ws;
  end

  int glitch = 0;
  logic pb = 1'b0, psd = 1'b0, pws = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (sdata !== psd || ws !== pws) && !(pb == 1'b1 && bclk == 1'b0))
      glitch++;
    pb = bclk; psd = sdata; pws = ws;
  end

  task automatic wait_until(input int target);
    while (fidx < target) @(posedge bclk);
    #1;
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      fifo_mem[wr_cnt & 255] = (32'h9E3779B9 * (wr_cnt + 1)) ^ 32'h5A5A00FF;
      wr_cnt++;
    end
  endtask

  function automatic logic [63:0] masked(input logic [31:0] w, input int er);
    return {32'b0, w} & ((64'd1 << er) - 64'd1);
  endfunction

  task automatic enable_now(output int f);
    @(posedge bclk); #1;
    tx_en = 1'b1;
    f = fidx;
  endtask

  task automatic run_cfg(input int r, input int q);
    int er, base, f, t0, k;
    @(negedge clk);
    ratio = 8'(q); res = 6'(r);
    er = (r == 0) ? 1 : ((r > 32) ? 32 : r);
    wait_until(fidx + 3);
    @(posedge bclk); t0 = mcyc;
    @(posedge bclk);
    chk(mcyc - t0 == 2 * (q + 2), "R1 bit clock period", 64'(mcyc - t0), 64'(2 * (q + 2)));
    base = wr_cnt;
    push_words(6);
    wait_until(fidx + 2);
    chk(rd_ptr == base, "R9 no pop while disabled", 64'(rd_ptr), 64'(base));
    enable_now(f);
    wait_until(f + 6);
    @(negedge clk) tx_en = 1'b0;
    k = (f + 1) & 1023;
    chk(fr_l[k] == 0 && fr_r[k] == 0, "R6 silent first frame", fr_l[k] | fr_r[k], 64'd0);
    for (int i = 0; i < 3; i++) begin
      k = (f + 2 + i) & 1023;
      chk(fr_l[k] == masked(fifo_mem[(base + 2 * i) & 255], er), "R3 left sample",
          fr_l[k], masked(fifo_mem[(base + 2 * i) & 255], er));
      chk(fr_r[k] == masked(fifo_mem[(base + 2 * i + 1) & 255], er), "R3 right sample",
          fr_r[k], masked(fifo_mem[(base + 2 * i + 1) & 255], er));
      chk(ur_l[k] == 1'b0, "R8 no underrun with data", 64'(ur_l[k]), 64'd0);
    end
    k = (f + 2) & 1023;
    chk(nb_l[k] == er && nb_r[k] == er, "R2 bits per slot", 64'(nb_l[k]), 64'(er));
    k = (f + 5) & 1023;
    chk(fr_l[k] == 0 && fr_r[k] == 0, "R8 zeros on empty queue", fr_l[k] | fr_r[k], 64'd0);
    chk(ur_l[k] == 1'b1, "R8 underrun flag", 64'(ur_l[k]), 64'd1);
    chk(rd_ptr == base + 6, "R7 two pops per data frame", 64'(rd_ptr), 64'(base + 6));
  endtask

  initial begin
    int base, f, k;
    for (int i = 0; i < 256; i++) fifo_mem[i] = '0;
    rst_n = 1'b0; tx_en = 1'b0; ratio = 8'd0; res = 6'd16;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(bclk == 0 && ws == 0 && sdata == 0, "R1 reset outputs low", {61'b0, bclk, ws, sdata}, 64'd0);
    chk(word_pop == 0 && underrun == 0, "R7 reset no pop", {62'b0, word_pop, underrun}, 64'd0);
    rst_n = 1'b1;

    for (int qi = 0; qi < 2; qi++) begin
      run_cfg(1, qi * 2);
      run_cfg(5, qi * 2);
      run_cfg(8, qi * 2);
      run_cfg(16, qi * 2);
      run_cfg(24, qi * 2);
      run_cfg(32, qi * 2);
      run_cfg(0, qi * 2);
      run_cfg(40, qi * 2);
    end

    @(negedge clk) ratio = 8'd1; res = 6'd8;
    wait_until(fidx + 3);
    base = wr_cnt;
    push_words(4);
    enable_now(f);
    wait_until(f + 3);
    tx_en = 1'b0;
    wait_until(f + 6);
    k = (f + 3) & 1023;
    chk(fr_l[k] == masked(fifo_mem[(base + 2) & 255], 8), "R9 frame finishes left",
        fr_l[k], masked(fifo_mem[(base + 2) & 255], 8));
    chk(fr_r[k] == masked(fifo_mem[(base + 3) & 255], 8), "R9 frame finishes right",
        fr_r[k], masked(fifo_mem[(base + 3) & 255], 8));
    for (int i = 4; i < 6; i++) begin
      k = (f + i) & 1023;
      chk(fr_l[k] == 0 && fr_r[k] == 0 && ur_l[k] == 0, "R9 silence after disable",
          fr_l[k] | fr_r[k] | 64'(ur_l[k]), 64'd0);
    end
    chk(rd_ptr == base + 4, "R9 pop count", 64'(rd_ptr), 64'(base + 4));

    base = wr_cnt;
    push_words(1);
    enable_now(f);
    wait_until(f + 4);
    @(negedge clk) tx_en = 1'b0;
    k = (f + 2) & 1023;
    chk(fr_l[k] == masked(fifo_mem[base & 255], 8), "R8 lone left word",
        fr_l[k], masked(fifo_mem[base & 255], 8));
    chk(fr_r[k] == 0 && ur_r[k] == 1 && ur_l[k] == 0, "R8 right shortage",
        fr_r[k] | {ur_l[k], ur_r[k]}, 64'd1);
    k = (f + 3) & 1023;
    chk(fr_l[k] == 0 && fr_r[k] == 0 && ur_l[k] == 1, "R8 left shortage",
        fr_l[k] | fr_r[k], 64'd0);
    chk(rd_ptr == base + 1, "R8 no right pop on empty", 64'(rd_ptr), 64'(base + 1));
    chk(glitch == 0, "R5 R4 changes only on falling bclk", 64'(glitch), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule